// File: doc/BRIEF.md
# Master-Mode Serial Audio Port

This block is a stereo serial audio port that is always the clock master. All logic runs on a single root audio clock, `clk`. From that clock it divides down a bit clock and a word-select clock. It shifts one left/right sample pair out on a serial data line during each frame. When reception is enabled, it shifts a pair in from a serial input line.

A set of configuration inputs selects the following:
- the word length;
- the placement of the word inside its half-frame;
- which word-select level marks the left channel;
- whether the port transmits, receives, or does both;
- how many root-clock cycles make up one sample period.

The port latches these inputs only where a frame begins, so a change never disturbs a frame that is already in progress.

Samples cross the parallel side through valid/ready handshakes and are aligned to bit 0. A one-entry holding stage accepts the next transmit pair at any point during the current frame. A received pair stays presented until the consumer takes it.

Top module: `i2s_port`

## Requirements
- R1: The bit clock period is `ratio`/64 root cycles. `cfg_ratio` 00 selects 256 (4 cycles), 01 selects 512 (8), 10 selects 384 (6) and 11 selects 768 (12). The bit clock is low for the first half of each period and high for the second half. A frame is 64 bit periods long, and each channel gets 32 of them.
- R2: When `cfg_lr_inv`=0, the word select is low during the left half-frame and high during the right. When `cfg_lr_inv`=1, the levels are swapped. The left half-frame comes first in every frame.
- R3: `cfg_fmt`=00 (standard format): the word's MSB is in slot 1 of the half-frame (the second bit period after the word-select edge). The remaining bits follow MSB first. Every other slot carries 0.
- R4: `cfg_fmt`=01 (left-justified): the MSB is in slot 0, which is the same bit period as the word-select edge. The remaining bits follow MSB first, and the rest of the half-frame is 0.
- R5: `cfg_fmt`=10 (right-justified): the LSB is in slot 31, the last slot before the next word-select edge. The leading slots carry 0.
- R6: `cfg_len` 00 selects 16 bits per channel, 01 selects 8 and 10 selects 24. Samples are bit-0 aligned on the parallel ports. Transmit bits above the word length are ignored. Received words have zeros above the word length.
- R7: Serial output data and word select change only in a cycle where the bit clock is low. Serial input is captured at the root edge that raises the bit clock.
- R8: A transmit pair is accepted when `tx_valid` and `tx_ready` are both high. After that, `tx_ready` stays low until the next frame start, where the pair is moved into the shifter. A frame that starts with the holding stage empty sends zeros.
- R9: At the end of a frame in which reception was enabled, `rx_valid` rises and `rx_left`/`rx_right` carry the received words. These stay stable until a cycle with `rx_ready` high. If a newer frame completes first, it replaces them.
- R10: `cfg_dir` 00 selects transmit only (no `rx_valid`). 01 selects receive only (`sd_o` stays 0 and no transmit pair is consumed). 10 selects both.
- R11: A reserved value (`cfg_len`=11, `cfg_fmt`=11 or `cfg_dir`=11) holds the bit clock, the word select and `sd_o` low. In that state `rx_valid` is not raised and no transmit pair is consumed.
- R12: Configuration inputs take effect only at a frame start, which is the start of a left half-frame. The first frame after reset begins at the first clock edge with reset released.
- R13: During reset, the bit clock, word select, `sd_o` and `rx_valid` are low, and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Word length select |
| cfg_fmt | input | 2 | Word placement select |
| cfg_lr_inv | input | 1 | Word-select polarity |
| cfg_dir | input | 2 | Transfer direction |
| cfg_ratio | input | 2 | Root-clock-to-sample-rate ratio |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Holding stage empty |
| tx_left | input | SW | Left transmit sample |
| tx_right | input | SW | Right transmit sample |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Received pair taken |
| rx_left | output | SW | Left received sample |
| rx_right | output | SW | Right received sample |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Word-select clock |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
A slip in the divider or slot counter shows up as a misplaced bit-clock or word-select edge, and it does so within a single bit period. Corrupted shifter or holding-stage contents appear as wrong serial bits during the same half-frame. They also arrive one frame later as a wrong received word. A configuration latched at the wrong moment shows up at the first frame boundary after the inputs change, as a shifted word-select edge, a changed bit-clock period or a misplaced MSB.

// File: rtl/i2s_port.sv
module i2s_port #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_len,
  input  logic [1:0]    cfg_fmt,
  input  logic          cfg_lr_inv,
  input  logic [1:0]    cfg_dir,
  input  logic [1:0]    cfg_ratio,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [SW-1:0] tx_left,
  input  logic [SW-1:0] tx_right,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [SW-1:0] rx_left,
  output logic [SW-1:0] rx_right,
  output logic          bclk_o,
  output logic          lrck_o,
  output logic          sd_o,
  input  logic          sd_i
);
  localparam int SLOTS = 64;
  localparam int SLW = $clog2(SLOTS);
  localparam int IW = $clog2(SW);
  localparam int CW = 4;

  logic           run, bfull, pol_q;
  logic [1:0]     len_q, fmt_q, dir_q, rat_q;
  logic [CW-1:0]  cnt, div, half;
  logic [SLW-1:0] slot;
  logic [SW-1:0]  buf_l, buf_r, act_l, act_r, sh_l, sh_r, sh_base, sh_next;
  logic [5:0]     nb, kk;
  logic [IW-1:0]  idx;
  logic           hit, legal, on, tx_en, rx_en, last, fend, bound, rise, take, bit_tx;

  always_comb begin
    case (rat_q)
      2'd0:    div = 4'd4;
      2'd1:    div = 4'd8;
      2'd2:    div = 4'd6;
      default: div = 4'd12;
    endcase
  end

  always_comb begin
    case (len_q)
      2'd1:    nb = 6'd8;
      2'd2:    nb = 6'd24;
      default: nb = 6'd16;
    endcase
  end

  assign half = div >> 1;
  assign kk   = {1'b0, slot[4:0]};

  always_comb begin
    hit = 1'b0;
    idx = '0;
    case (fmt_q)
      2'd0: begin hit = (kk != 6'd0) && (kk <= nb); idx = IW'(nb - kk); end
      2'd1: begin hit = kk < nb; idx = IW'(nb - 6'd1 - kk); end
      2'd2: begin hit = kk >= (6'd32 - nb); idx = IW'(6'd31 - kk); end
      default: ;
    endcase
  end

  assign legal = (len_q != 2'd3) && (fmt_q != 2'd3) && (dir_q != 2'd3);
  assign on    = run && legal;
  assign tx_en = (dir_q == 2'd0) || (dir_q == 2'd2);
  assign rx_en = (dir_q == 2'd1) || (dir_q == 2'd2);
  assign last  = cnt == div - 4'd1;
  assign fend  = last && (&slot);
  assign bound = !run || fend;
  assign rise  = cnt == half - 4'd1;
  assign take  = (cfg_len != 2'd3) && (cfg_fmt != 2'd3) &&
                 ((cfg_dir == 2'd0) || (cfg_dir == 2'd2));

  assign bit_tx  = hit && (slot[SLW-1] ? act_r[idx] : act_l[idx]);
  assign sh_base = (kk == 6'd0) ? '0 : (slot[SLW-1] ? sh_r : sh_l);
  assign sh_next = hit ? {sh_base[SW-2:0], sd_i} : sh_base;

  assign bclk_o   = on && (cnt >= half);
  assign lrck_o   = on && (slot[SLW-1] ^ pol_q);
  assign sd_o     = on && tx_en && bit_tx;
  assign tx_ready = !bfull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      slot  <= '0;
      len_q <= '0;
      fmt_q <= '0;
      dir_q <= '0;
      rat_q <= '0;
      pol_q <= 1'b0;
    end else if (bound) begin
      run   <= 1'b1;
      cnt   <= '0;
      slot  <= '0;
      len_q <= cfg_len;
      fmt_q <= cfg_fmt;
      dir_q <= cfg_dir;
      rat_q <= cfg_ratio;
      pol_q <= cfg_lr_inv;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (last) slot <= slot + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bfull <= 1'b0;
      buf_l <= '0;
      buf_r <= '0;
      act_l <= '0;
      act_r <= '0;
    end else begin
      if (bound && take) begin
        act_l <= bfull ? buf_l : '0;
        act_r <= bfull ? buf_r : '0;
        bfull <= 1'b0;
      end
      if (tx_valid && !bfull) begin
        buf_l <= tx_left;
        buf_r <= tx_right;
        bfull <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l     <= '0;
      sh_r     <= '0;
      rx_valid <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
    end else begin
      if (on && rx_en && rise) begin
        if (slot[SLW-1]) sh_r <= sh_next;
        else             sh_l <= sh_next;
      end
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (on && rx_en && fend) begin
        rx_valid <= 1'b1;
        rx_left  <= sh_l;
        rx_right <= sh_r;
      end
    end
  end
endmodule

module i2s_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_o,
  input logic lrck_o,
  input logic sd_o,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready
);
  // R7
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_o) |-> !bclk_o);

  // R2
  lr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck_o) |-> !bclk_o);

  // R1
  bclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_o) |=> bclk_o);

  // R1
  bclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk_o) |=> !bclk_o);

  // R8
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);
endmodule

bind i2s_port i2s_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_o(bclk_o), .lrck_o(lrck_o), .sd_o(sd_o),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/i2s_port_tb.sv
module i2s_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;
  localparam int NPH = 20;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] cfg_len = 2'd0, cfg_fmt = 2'd0, cfg_dir = 2'd2, cfg_ratio = 2'd0;
  logic cfg_lr_inv = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, sd_i = 1'b0;
  logic [SW-1:0] tx_left = '0, tx_right = '0;
  logic tx_ready, rx_valid, bclk_o, lrck_o, sd_o;
  logic [SW-1:0] rx_left, rx_right;

  i2s_port #(.SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_fmt(cfg_fmt),
    .cfg_lr_inv(cfg_lr_inv), .cfg_dir(cfg_dir), .cfg_ratio(cfg_ratio),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right),
    .bclk_o(bclk_o), .lrck_o(lrck_o), .sd_o(sd_o), .sd_i(sd_i)
  );

  int checks = 0, errs = 0, cyc = 0, phase = 0, next_at = 0;
  string tag = "R13 reset";

  bit m_run, m_bfull, m_rxv, acc_pend, rxt_pend, sdi_prev;
  int m_cnt, m_slot;
  logic [1:0] m_len, m_fmt, m_dir, m_rat;
  logic m_pol;
  logic [SW-1:0] m_buf_l, m_buf_r, m_act_l, m_act_r, m_shl, m_shr, m_rxl, m_rxr;

  function automatic int div_of(logic [1:0] r);
    case (r) 2'd0: return 4; 2'd1: return 8; 2'd2: return 6; default: return 12; endcase
  endfunction
  function automatic int bits_of(logic [1:0] l);
    case (l) 2'd1: return 8; 2'd2: return 24; default: return 16; endcase
  endfunction
  function automatic int first_of(logic [1:0] f, int n);
    case (f) 2'd0: return 1; 2'd1: return 0; default: return 32 - n; endcase
  endfunction
  function automatic bit in_word(logic [1:0] f, int n, int k);
    int s = first_of(f, n);
    return (k >= s) && (k < s + n);
  endfunction
  function automatic bit ser_bit(logic [1:0] f, int n, int k, logic [SW-1:0] w);
    if (!in_word(f, n, k)) return 1'b0;
    return w[n - 1 - (k - first_of(f, n))];
  endfunction
  function automatic bit legal_of(logic [1:0] l, logic [1:0] f, logic [1:0] d);
    return (l != 2'd3) && (f != 2'd3) && (d != 2'd3);
  endfunction
  function automatic bit txen(logic [1:0] d); return (d == 2'd0) || (d == 2'd2); endfunction
  function automatic bit rxen(logic [1:0] d); return (d == 2'd1) || (d == 2'd2); endfunction

  task automatic chk1(input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %0b expected %0b (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask
  task automatic chkw(input string what, input logic [SW-1:0] got, input logic [SW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic model_reset();
    m_run = 0; m_bfull = 0; m_rxv = 0; m_cnt = 0; m_slot = 0;
    m_len = 0; m_fmt = 0; m_dir = 0; m_rat = 0; m_pol = 0;
    m_buf_l = '0; m_buf_r = '0; m_act_l = '0; m_act_r = '0;
    m_shl = '0; m_shr = '0; m_rxl = '0; m_rxr = '0;
  endtask

  task automatic model_step();
    int div, half, n, k;
    bit on, last, fend, rt;
    logic [SW-1:0] s;
    div = div_of(m_rat); half = div / 2; n = bits_of(m_len);
    k = m_slot % 32; rt = m_slot >= 32;
    on = m_run && legal_of(m_len, m_fmt, m_dir);
    last = m_cnt == div - 1;
    fend = last && (m_slot == 63);
    if (on && rxen(m_dir) && m_cnt == half - 1) begin
      s = rt ? m_shr : m_shl;
      if (k == 0) s = '0;
      if (in_word(m_fmt, n, k)) s = {s[SW-2:0], sdi_prev};
      if (rt) m_shr = s; else m_shl = s;
    end
    if (rxt_pend) m_rxv = 0;
    if (on && rxen(m_dir) && fend) begin m_rxv = 1; m_rxl = m_shl; m_rxr = m_shr; end
    if (!m_run || fend) begin
      m_len = cfg_len; m_fmt = cfg_fmt; m_dir = cfg_dir; m_rat = cfg_ratio; m_pol = cfg_lr_inv;
      m_run = 1; m_cnt = 0; m_slot = 0;
      if (legal_of(cfg_len, cfg_fmt, cfg_dir) && txen(cfg_dir)) begin
        m_act_l = m_bfull ? m_buf_l : '0;
        m_act_r = m_bfull ? m_buf_r : '0;
        m_bfull = 0;
      end
    end else if (last) begin
      m_cnt = 0; m_slot++;
    end else begin
      m_cnt++;
    end
    if (acc_pend) begin m_buf_l = tx_left; m_buf_r = tx_right; m_bfull = 1; end
  endtask

  task automatic compare();
    bit on, e_b, e_lr, e_sd;
    int n, k;
    on = m_run && legal_of(m_len, m_fmt, m_dir);
    n = bits_of(m_len); k = m_slot % 32;
    e_b  = on && (m_cnt >= div_of(m_rat) / 2);
    e_lr = on && ((m_slot >= 32) != m_pol);
    e_sd = on && txen(m_dir) && ser_bit(m_fmt, n, k, (m_slot >= 32) ? m_act_r : m_act_l);
    chk1("bclk_o R1", bclk_o, e_b);
    chk1("lrck_o R2 R12", lrck_o, e_lr);
    chk1("sd_o R7 R3/R4/R5 R6", sd_o, e_sd);
    chk1("tx_ready R8", tx_ready, !m_bfull);
    chk1("rx_valid R9 R10", rx_valid, m_rxv);
    if (m_rxv) begin
      chkw("rx_left R9 R6", rx_left, m_rxl);
      chkw("rx_right R9 R6", rx_right, m_rxr);
    end
  endtask

  task automatic apply(input logic [1:0] l, input logic [1:0] f, input logic p,
                       input logic [1:0] d, input logic [1:0] r, input string t);
    cfg_len = l; cfg_fmt = f; cfg_lr_inv = p; cfg_dir = d; cfg_ratio = r; tag = t;
  endtask

  task automatic set_phase(input int p);
    case (p)
      0:  apply(2'd0, 2'd0, 1'b0, 2'd2, 2'd0, "R3 R6 standard 16-bit");
      1:  apply(2'd1, 2'd1, 1'b0, 2'd2, 2'd1, "R4 R6 left-justified 8-bit");
      2:  apply(2'd2, 2'd2, 1'b1, 2'd2, 2'd2, "R5 R2 right-justified 24-bit inverted");
      3:  apply(2'd0, 2'd2, 1'b0, 2'd0, 2'd3, "R10 transmit only 768");
      4:  apply(2'd2, 2'd0, 1'b1, 2'd1, 2'd0, "R10 receive only");
      5:  apply(2'd3, 2'd0, 1'b0, 2'd2, 2'd0, "R11 reserved length");
      6:  apply(2'd0, 2'd3, 1'b0, 2'd2, 2'd1, "R11 reserved format");
      7:  apply(2'd0, 2'd1, 1'b0, 2'd3, 2'd2, "R11 reserved direction");
      8:  apply(2'd1, 2'd2, 1'b1, 2'd2, 2'd3, "R5 right-justified 8-bit");
      9:  apply(2'd2, 2'd1, 1'b0, 2'd2, 2'd1, "R4 left-justified 24-bit");
      10: apply(2'd1, 2'd0, 1'b1, 2'd2, 2'd2, "R3 standard 8-bit inverted");
      default: apply(2'($urandom()), 2'($urandom()), 1'($urandom()),
                     2'($urandom()), 2'($urandom()), "R12 random mode change");
    endcase
  endtask

  initial void'($urandom(32'd4242));

  always @(negedge clk) begin : drive
    bit adv;
    if (!rst_n) model_reset(); else model_step();
    compare();
    cyc++;
    adv = acc_pend;
    if (cyc > LIMIT) begin
      errs++;
      $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, LIMIT);
      finish_run();
    end
    if (cyc == 4) begin
      rst_n = 1'b1;
      set_phase(0);
      next_at = cyc + 3000;
    end else if (rst_n && cyc == next_at) begin
      phase++;
      if (phase == NPH) finish_run();
      set_phase(phase);
      next_at = cyc + 2500 + int'($urandom() % 1500);
    end
    if (adv || cyc == 4) begin
      tx_left  = SW'($urandom());
      tx_right = SW'($urandom());
    end
    tx_valid = ($urandom() % 4) != 0;
    rx_ready = ($urandom() % 3) != 0;
    sd_i     = 1'($urandom());
    sdi_prev = sd_i;
    acc_pend = rst_n && tx_valid && !m_bfull;
    rxt_pend = rst_n && m_rxv && rx_ready;
  end
endmodule